// File: doc/BRIEF.md
# Shared-Bus Channel Enable Latch Bank

This block holds the static per-channel configuration of a four-channel serial transceiver. One 8-bit enable bus is shared by three configuration latches: a serial output-enable latch, a built-in self-test (BIST) enable latch and a receive power-enable latch. Each latch has its own active-high load strobe. While its strobe is high, a latch is transparent and follows the bus. When the strobe drops, the latch keeps the last bus value. Software or board logic programs all three latches by driving the bus and then pulsing one strobe at a time.

The latches are modelled synchronously on a system clock. Each strobe passes through a two-flop synchronizer, and while the synchronized strobe is high the latch loads on every clock edge. The BIST latch stores active-low enables, which the block decodes into active-high per-channel transmit and receive BIST controls. The block also produces a registered, active-low link-fault flag for each channel. The flag combines three analog fault conditions with the channel's own receive power-down state.

There is no data stream through the block. All of its pins are plain control and status levels, with no handshake.

Top module: `chlatch_bank`

## Requirements
- R1: A strobe first sampled high at rising edge k makes its latch take the value of `en_bus` at edge k+2. The latch keeps loading at every edge while the synchronized strobe stays high. At edge k+1 the outputs still show the old contents.
- R2: From the third edge after a strobe is last sampled high, that latch's outputs stay constant whatever `en_bus` does.
- R3: Synchronous reset (`rst_n` low at an edge) sets `serial_oe` to all ones, which enables every serial output.
- R4: In the BIST latch, a 0 bit means BIST is active. Bits [3:0] control transmit pattern generation on channels 0..3 (`tx_bist_on`), and bits [7:4] control receive pattern comparison on channels 0..3 (`rx_bist_on`). Both outputs are active-high.
- R5: Reset clears the BIST latch to all ones (no BIST on any channel) only when its synchronized strobe is low. While that strobe is high, the latch keeps loading `en_bus` during reset.
- R6: Bits [3:0] of the power latch drive `rx_pwr_en` for channels 0..3, where 1 means powered up. Bits [7:4] of `en_bus` have no effect on `rx_pwr_en`.
- R7: Reset clears `rx_pwr_en` to all zeros, whatever the strobe is doing.
- R8: `link_fault_n[i]` is registered. After each edge it is low exactly when, at that edge, `freq_err[i]`, `amp_low[i]` or `dens_low[i]` was high or `rx_pwr_en[i]` was low. It is low in reset.
- R9: Loading one latch leaves the contents of the other two latches unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| en_bus | input | 8 | Shared enable bus |
| oe_le | input | 1 | Output-enable latch strobe, active high |
| bist_le | input | 1 | BIST latch strobe, active high |
| rxpwr_le | input | 1 | Receive power latch strobe, active high |
| freq_err | input | 4 | Per-channel received frequency out of range |
| amp_low | input | 4 | Per-channel signal amplitude too low |
| dens_low | input | 4 | Per-channel transition density too low |
| serial_oe | output | 8 | Latched serial output enables |
| tx_bist_on | output | 4 | Transmit BIST pattern generation active, per channel |
| rx_bist_on | output | 4 | Receive BIST pattern comparison active, per channel |
| rx_pwr_en | output | 4 | Receive channel power enable, per channel |
| link_fault_n | output | 4 | Link fault, active low, per channel |

## Verification
The bench builds the block with its defaults: four channels, which gives an eight-bit bus, and two synchronizer stages. With two stages the load latency is short and fixed, so the bench can check the cycle before the load and the load cycle itself. The BIST bit split places transmit and receive enables in different nibbles, so one asymmetric pattern shows whether the two nibbles are swapped or the polarity is inverted. With a narrow power latch, the ignored upper bits and each fault source can be exercised one channel at a time.

// File: rtl/chlatch_pkg.sv
package chlatch_pkg;
  typedef enum int unsigned {
    LAT_OE   = 0,
    LAT_BIST = 1,
    LAT_PWR  = 2
  } lat_idx_e;

  localparam int unsigned NUM_LAT = 3;
endpackage

// File: rtl/chlatch_sync.sv
module chlatch_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/chlatch_cfg.sv
module chlatch_cfg #(
  parameter int unsigned W            = 8,
  parameter logic [W-1:0] RST_VAL     = '0,
  parameter bit          HOLD_IF_OPEN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic do_rst;

  generate
    if (HOLD_IF_OPEN) begin : g_gated_rst
      assign do_rst = !rst_n && !open_i;
    end else begin : g_plain_rst
      assign do_rst = !rst_n;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_rst)      q <= RST_VAL;
    else if (open_i) q <= d;
  end
endmodule

// File: rtl/chlatch_fault.sv
module chlatch_fault #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] freq_err,
  input  logic [NUM_CH-1:0] amp_low,
  input  logic [NUM_CH-1:0] dens_low,
  input  logic [NUM_CH-1:0] pwr_en,
  output logic [NUM_CH-1:0] fault_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) fault_n <= '0;
    else begin
      for (int i = 0; i < NUM_CH; i++) begin
        fault_n[i] <= !(freq_err[i] || amp_low[i] || dens_low[i] || !pwr_en[i]);
      end
    end
  end
endmodule

// File: rtl/chlatch_bank.sv
module chlatch_bank
  import chlatch_pkg::*;
#(
  parameter  int unsigned NUM_CH      = 4,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned BUS_W       = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  en_bus,
  input  logic              oe_le,
  input  logic              bist_le,
  input  logic              rxpwr_le,
  input  logic [NUM_CH-1:0] freq_err,
  input  logic [NUM_CH-1:0] amp_low,
  input  logic [NUM_CH-1:0] dens_low,
  output logic [BUS_W-1:0]  serial_oe,
  output logic [NUM_CH-1:0] tx_bist_on,
  output logic [NUM_CH-1:0] rx_bist_on,
  output logic [NUM_CH-1:0] rx_pwr_en,
  output logic [NUM_CH-1:0] link_fault_n
);
  logic [NUM_LAT-1:0] le_raw;
  logic [NUM_LAT-1:0] le_open;
  logic [BUS_W-1:0]   bist_q;

  assign le_raw[LAT_OE]   = oe_le;
  assign le_raw[LAT_BIST] = bist_le;
  assign le_raw[LAT_PWR]  = rxpwr_le;

  // One synchronizer per strobe
  for (genvar g = 0; g < NUM_LAT; g++) begin : g_sync
    chlatch_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .d   (le_raw[g]),
      .q   (le_open[g])
    );
  end

  chlatch_cfg #(.W(BUS_W), .RST_VAL({BUS_W{1'b1}}), .HOLD_IF_OPEN(1'b0)) oe_lat_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (le_open[LAT_OE]),
    .d      (en_bus),
    .q      (serial_oe)
  );

  chlatch_cfg #(.W(BUS_W), .RST_VAL({BUS_W{1'b1}}), .HOLD_IF_OPEN(1'b1)) bist_lat_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (le_open[LAT_BIST]),
    .d      (en_bus),
    .q      (bist_q)
  );

  // Only the low half of the bus is stored for power enables
  chlatch_cfg #(.W(NUM_CH), .RST_VAL({NUM_CH{1'b0}}), .HOLD_IF_OPEN(1'b0)) pwr_lat_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (le_open[LAT_PWR]),
    .d      (en_bus[NUM_CH-1:0]),
    .q      (rx_pwr_en)
  );

  // Stored bits are active-low enables
  assign tx_bist_on = ~bist_q[NUM_CH-1:0];
  assign rx_bist_on = ~bist_q[BUS_W-1:NUM_CH];

  chlatch_fault #(.NUM_CH(NUM_CH)) fault_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .freq_err (freq_err),
    .amp_low  (amp_low),
    .dens_low (dens_low),
    .pwr_en   (rx_pwr_en),
    .fault_n  (link_fault_n)
  );
endmodule

// File: rtl/chlatch_bank_chk.sv
module chlatch_bank_chk #(
  parameter  int unsigned NUM_CH = 4,
  localparam int unsigned BUS_W  = 2 * NUM_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_W-1:0]  en_bus,
  input logic              bist_le,
  input logic              rxpwr_le,
  input logic [NUM_CH-1:0] freq_err,
  input logic [NUM_CH-1:0] amp_low,
  input logic [NUM_CH-1:0] dens_low,
  input logic [BUS_W-1:0]  serial_oe,
  input logic [NUM_CH-1:0] tx_bist_on,
  input logic [NUM_CH-1:0] rx_bist_on,
  input logic [NUM_CH-1:0] rx_pwr_en,
  input logic [NUM_CH-1:0] link_fault_n
);
  AST_OE_RST_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> serial_oe == {BUS_W{1'b1}}); // R3

  AST_PWR_RST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> rx_pwr_en == '0); // R7

  AST_BIST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bist_le, 3)) |-> {rx_bist_on, tx_bist_on} == ~$past(en_bus)); // R1

  AST_BIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bist_le, 3)) |-> $stable({rx_bist_on, tx_bist_on})); // R2

  AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rxpwr_le, 3)) |-> $stable(rx_pwr_en)); // R2

  AST_LINK_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> link_fault_n ==
      ~($past(freq_err) | $past(amp_low) | $past(dens_low) | ~$past(rx_pwr_en))); // R8
endmodule

bind chlatch_bank chlatch_bank_chk #(.NUM_CH(NUM_CH)) chk_i (.*);

// File: tb/chlatch_bank_tb_top.sv
`timescale 1ns/100ps
module chlatch_bank_tb_top;
  localparam int NCH = 4;
  localparam int BW  = 2 * NCH;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [BW-1:0]  en_bus = '0;
  logic [2:0]     les = '0;
  logic [NCH-1:0] freq_err = '0, amp_low = '0, dens_low = '0;
  logic [BW-1:0]  serial_oe;
  logic [NCH-1:0] tx_bist_on, rx_bist_on, rx_pwr_en, link_fault_n;

  always #2.5 clk = ~clk;

  chlatch_bank #(.NUM_CH(NCH), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_bus(en_bus),
    .oe_le(les[0]), .bist_le(les[1]), .rxpwr_le(les[2]),
    .freq_err(freq_err), .amp_low(amp_low), .dens_low(dens_low),
    .serial_oe(serial_oe), .tx_bist_on(tx_bist_on), .rx_bist_on(rx_bist_on),
    .rx_pwr_en(rx_pwr_en), .link_fault_n(link_fault_n)
  );

  typedef struct {
    int       kind;
    logic [7:0] exp;
    string    req;
    time      stamp;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Bench model of latch contents
  logic [7:0] m_oe = 8'hFF, m_bist = 8'hFF;
  logic [3:0] m_pwr = 4'h0;

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req; it.stamp = $time;
    q.push_back(it);
  endtask

  // Expectations hold after the next rising edge
  task automatic push_state(string req);
    push(0, m_oe, req);
    push(1, {4'h0, ~m_bist[3:0]}, req);
    push(2, {4'h0, ~m_bist[7:4]}, req);
    push(3, {4'h0, m_pwr}, req);
  endtask

  task automatic load(int sel, logic [7:0] v, string req);
    en_bus = v; les[sel] = 1'b1;
    push_state("R1/R9");
    cyc(1);
    push_state("R1");
    cyc(1);
    case (sel)
      0: m_oe = v;
      1: m_bist = v;
      default: m_pwr = v[3:0];
    endcase
    push_state(req);
    cyc(1);
    les[sel] = 1'b0;
    cyc(3);
    en_bus = ~v;
    push_state("R2");
    cyc(2);
  endtask

  // Monitor: compare items pushed before this falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].stamp < $time) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = serial_oe;
          1: act = {4'h0, tx_bist_on};
          2: act = {4'h0, rx_bist_on};
          3: act = {4'h0, rx_pwr_en};
          default: act = {4'h0, link_fault_n};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h at %0t",
                   it.req, it.kind, act, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(4);
    // Reset state: R3 OE ones, R5 BIST off, R7 power off, R8 faults low
    push(0, 8'hFF, "R3");
    push(1, 8'h00, "R5");
    push(2, 8'h00, "R5");
    push(3, 8'h00, "R7");
    push(4, 8'h00, "R8");
    cyc(1);
    rst_n = 1'b1;
    cyc(2);

    load(0, 8'h5A, "R1");
    load(1, 8'hA6, "R4");      // tx_bist_on=9, rx_bist_on=5
    load(2, 8'hA5, "R6");      // power = 5
    load(2, 8'h55, "R6");      // upper nibble differs, power still 5

    // R8 link-fault combinations with power 0101
    push(4, 8'h05, "R8"); cyc(1);
    freq_err = 4'b0001; push(4, 8'h04, "R8"); cyc(1);
    freq_err = 4'b0000; amp_low = 4'b0100; push(4, 8'h01, "R8"); cyc(1);
    amp_low = 4'b0000; dens_low = 4'b0001; push(4, 8'h04, "R8"); cyc(1);
    dens_low = 4'b0000;
    load(2, 8'h0F, "R1");
    push(4, 8'h0F, "R8"); cyc(1);
    cyc(1);

    // R5 reset while BIST strobe open keeps loading
    en_bus = 8'h3C; les[1] = 1'b1;
    cyc(3);
    rst_n = 1'b0;
    m_bist = 8'h3C; m_oe = 8'hFF; m_pwr = 4'h0;
    cyc(1);
    push_state("R5"); push(4, 8'h00, "R8");
    cyc(1);
    rst_n = 1'b1; les[1] = 1'b0;
    cyc(3);
    // R5 reset with strobe closed clears BIST
    rst_n = 1'b0; m_bist = 8'hFF;
    push_state("R5");
    cyc(1);
    rst_n = 1'b1;
    cyc(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule